// File: doc/BRIEF.md
# Folding Branch Target Buffer

This block sits beside the fetch stage and is read with the fetch address each cycle. A small direct-mapped table remembers, per branch, an address tag, the predicted destination, a two-bit direction counter, a flag marking unconditional jumps, and the instruction word found at the destination. When the fetch address hits an entry that predicts taken, the block supplies that stored destination instruction to decode in place of the branch. It also steers the following fetch to the word after the destination, so a correctly predicted taken branch costs no cycle.

A second port is driven when a branch resolves in the back end. It carries the branch address, the outcome, whether the branch was an unconditional jump, the resolved destination and the instruction at that destination. The port allocates, trains or refreshes the matching entry. Table writes land on the clock edge, so a lookup in the same cycle as a write still sees the old contents.

Top module: `fold_btb`

## Requirements
- R1: After synchronous reset every entry is invalid, so no lookup hits until a resolve has written one.
- R2: The entry index is lookup_pc[5:2] and the tag is lookup_pc[31:6]. A lookup hits only when lookup_valid is 1, the indexed entry is valid and its tag equals the address tag.
- R3: On a miss, or on a hit whose prediction is not taken, next_pc is lookup_pc + 4, fold_valid is 0 and fold_instr is 0.
- R4: On a hit predicted taken, in the same cycle, pred_taken and fold_valid are 1, fold_instr is the stored destination instruction, and next_pc is the stored destination + 4.
- R5: An entry predicts taken when its counter value (0 to 3) is 2 or 3, or when it is marked unconditional.
- R6: A resolve that misses the table and is taken or unconditional writes the indexed entry, replacing any occupant. The new entry has counter 2, or counter 3 when unconditional, and holds the new tag, destination and instruction.
- R7: A resolve that misses the table and is neither taken nor unconditional leaves the table unchanged, and an occupant of that index still hits.
- R8: A conditional resolve that hits moves the counter up by one when taken and down by one when not taken, saturating at 3 and 0. A taken outcome also replaces the stored destination and instruction; a not-taken outcome keeps them.
- R9: A resolve with upd_uncond = 1 sets the entry's unconditional mark and counter 3. A marked entry keeps predicting taken under later conditional not-taken resolves until it is replaced.
- R10: A resolve write becomes visible to lookups on the cycle after the one in which upd_valid is asserted, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Fetch lookup request |
| lookup_pc | input | 32 | Fetch address, word aligned |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Hit predicted taken |
| next_pc | output | 32 | Address of the next fetch |
| fold_valid | output | 1 | Substitute instruction for decode is valid |
| fold_instr | output | 32 | Stored destination instruction for decode |
| upd_valid | input | 1 | Resolved branch report |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome was taken |
| upd_uncond | input | 1 | Resolved branch is an unconditional jump |
| upd_target | input | 32 | Resolved destination address |
| upd_target_instr | input | 32 | Instruction at the resolved destination |

## Verification
The bench uses the package defaults: a 32-bit address, a 32-bit instruction word and sixteen entries. Random addresses are drawn from four indexes and three tags, so aliasing on a shared index, replacement of an occupant, counter saturation at both ends and conversion of conditional entries to unconditional ones happen hundreds of times per run. Directed sequences separately pin down the same-cycle write-versus-lookup ordering and the not-taken miss that must leave an occupant untouched.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int PC_W    = 32;
    localparam int INSTR_W = 32;
    localparam int IDX_W   = 4;
    localparam int ALIGN_W = 2;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = PC_W - IDX_W - ALIGN_W;
    localparam logic [PC_W-1:0] WORD_BYTES = PC_W'(1 << ALIGN_W);

    typedef logic [1:0]         ctr_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [PC_W-1:0]    pc_t;
    typedef logic [INSTR_W-1:0] instr_t;

    localparam ctr_t CTR_MIN     = 2'd0;
    localparam ctr_t CTR_WEAK_T  = 2'd2;
    localparam ctr_t CTR_STRONG_T = 2'd3;

    typedef struct packed {
        logic   valid;
        logic   uncond;
        ctr_t   ctr;
        tag_t   tag;
        pc_t    target;
        instr_t instr;
    } entry_t;

    function automatic idx_t pc_index(input pc_t pc);
        return pc[ALIGN_W +: IDX_W];
    endfunction

    function automatic tag_t pc_tag(input pc_t pc);
        return pc[PC_W-1 -: TAG_W];
    endfunction

    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        if (taken)
            return (c == CTR_STRONG_T) ? c : c + 2'd1;
        else
            return (c == CTR_MIN) ? c : c - 2'd1;
    endfunction

    function automatic logic predicts_taken(input entry_t e);
        return e.uncond || e.ctr[1];
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  idx_t   wr_idx,
    input  entry_t wr_data,
    input  idx_t   rd_idx_a,
    input  idx_t   rd_idx_b,
    output entry_t rd_a,
    output entry_t rd_b
);

    entry_t slots [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        entry_t slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (wr_en && wr_idx == idx_t'(i))
                slot_q <= wr_data;
        end
        assign slots[i] = slot_q;
    end

    assign rd_a = slots[rd_idx_a];
    assign rd_b = slots[rd_idx_b];

    // R10: a write is held in the slot on the following cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (slots[$past(wr_idx)] == $past(wr_data)));

    // R1: the table comes out of reset empty
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_a.valid && !rd_b.valid));

endmodule

// File: rtl/btb_match.sv
module btb_match
    import btb_pkg::*;
(
    input  logic   req,
    input  pc_t    pc,
    input  entry_t ent,
    output logic   hit
);

    assign hit = req && ent.valid && (ent.tag == pc_tag(pc));

endmodule

// File: rtl/btb_policy.sv
module btb_policy
    import btb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd_valid,
    input  pc_t    upd_pc,
    input  logic   upd_taken,
    input  logic   upd_uncond,
    input  pc_t    upd_target,
    input  instr_t upd_instr,
    input  entry_t cur,
    input  logic   cur_hit,
    output logic   wr_en,
    output entry_t wr_data
);

    logic redirect;
    assign redirect = upd_taken || upd_uncond;

    always_comb begin
        wr_en   = 1'b0;
        wr_data = cur;
        if (upd_valid) begin
            if (cur_hit) begin
                wr_en = 1'b1;
                if (upd_uncond) begin
                    wr_data.uncond = 1'b1;
                    wr_data.ctr    = CTR_STRONG_T;
                end else begin
                    wr_data.ctr = ctr_step(cur.ctr, upd_taken);
                end
                if (redirect) begin
                    wr_data.target = upd_target;
                    wr_data.instr  = upd_instr;
                end
            end else if (redirect) begin
                wr_en          = 1'b1;
                wr_data.valid  = 1'b1;
                wr_data.uncond = upd_uncond;
                wr_data.ctr    = upd_uncond ? CTR_STRONG_T : CTR_WEAK_T;
                wr_data.tag    = pc_tag(upd_pc);
                wr_data.target = upd_target;
                wr_data.instr  = upd_instr;
            end
        end
    end

    // R7: a not-taken miss never writes
    a_r7_nt_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && !upd_uncond && !cur_hit) |-> !wr_en);

    // R6: a conditional taken miss allocates weakly taken
    a_r6_alloc_weak: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && !upd_uncond && !cur_hit) |->
        (wr_en && wr_data.valid && wr_data.ctr == CTR_WEAK_T));

    // R9: an unconditional resolve always leaves a strong, marked entry
    a_r9_uncond_strong: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_uncond) |->
        (wr_en && wr_data.uncond && wr_data.ctr == CTR_STRONG_T));

endmodule

// File: rtl/fold_btb.sv
module fold_btb
    import btb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                lookup_valid,
    input  logic [PC_W-1:0]     lookup_pc,
    output logic                pred_hit,
    output logic                pred_taken,
    output logic [PC_W-1:0]     next_pc,
    output logic                fold_valid,
    output logic [INSTR_W-1:0]  fold_instr,
    input  logic                upd_valid,
    input  logic [PC_W-1:0]     upd_pc,
    input  logic                upd_taken,
    input  logic                upd_uncond,
    input  logic [PC_W-1:0]     upd_target,
    input  logic [INSTR_W-1:0]  upd_target_instr
);

    entry_t look_e, upd_e, wr_data;
    logic   look_hit, upd_hit, wr_en;

    btb_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (pc_index(upd_pc)),
        .wr_data  (wr_data),
        .rd_idx_a (pc_index(lookup_pc)),
        .rd_idx_b (pc_index(upd_pc)),
        .rd_a     (look_e),
        .rd_b     (upd_e)
    );

    btb_match u_look_match (
        .req (lookup_valid),
        .pc  (lookup_pc),
        .ent (look_e),
        .hit (look_hit)
    );

    btb_match u_upd_match (
        .req (upd_valid),
        .pc  (upd_pc),
        .ent (upd_e),
        .hit (upd_hit)
    );

    btb_policy u_policy (
        .clk        (clk),
        .rst        (rst),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_uncond (upd_uncond),
        .upd_target (upd_target),
        .upd_instr  (upd_target_instr),
        .cur        (upd_e),
        .cur_hit    (upd_hit),
        .wr_en      (wr_en),
        .wr_data    (wr_data)
    );

    logic steer;
    assign steer      = look_hit && predicts_taken(look_e);
    assign pred_hit   = look_hit;
    assign pred_taken = steer;
    assign fold_valid = steer;
    assign fold_instr = steer ? look_e.instr : '0;
    assign next_pc    = (steer ? look_e.target : lookup_pc) + WORD_BYTES;

    // R3: without a taken prediction the fetch falls through
    a_r3_fall_through: assert property (@(posedge clk) disable iff (rst)
        (lookup_valid && !pred_taken) |->
        (next_pc == lookup_pc + WORD_BYTES && !fold_valid && fold_instr == '0));

    // R4: a folded instruction only comes from a table hit
    a_r4_fold_from_hit: assert property (@(posedge clk) disable iff (rst)
        fold_valid |-> (pred_hit && lookup_valid));

endmodule

// File: tb/sim_fold_btb.sv
`timescale 1ns/1ps
module sim_fold_btb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lookup_valid = 1'b0;
    logic [31:0] lookup_pc = '0;
    logic        pred_hit, pred_taken, fold_valid;
    logic [31:0] next_pc, fold_instr;
    logic        upd_valid = 1'b0, upd_taken = 1'b0, upd_uncond = 1'b0;
    logic [31:0] upd_pc = '0, upd_target = '0, upd_target_instr = '0;

    always #2 clk = ~clk;

    fold_btb u0 (
        .clk(clk), .rst(rst),
        .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .next_pc(next_pc),
        .fold_valid(fold_valid), .fold_instr(fold_instr),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_uncond(upd_uncond), .upd_target(upd_target),
        .upd_target_instr(upd_target_instr)
    );

    int checks = 0;
    int fails  = 0;

    // bench model of the table
    bit          m_valid [16];
    bit          m_unc   [16];
    int          m_ctr   [16];
    logic [25:0] m_tag   [16];
    logic [31:0] m_tgt   [16];
    logic [31:0] m_ins   [16];

    function automatic bit m_hit(logic [31:0] pc);
        return m_valid[pc[5:2]] && m_tag[pc[5:2]] == pc[31:6];
    endfunction

    function automatic bit m_taken(logic [31:0] pc);
        return m_hit(pc) && (m_unc[pc[5:2]] || m_ctr[pc[5:2]] >= 2);
    endfunction

    task automatic m_clear();
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 0; m_unc[i] = 0; m_ctr[i] = 0;
            m_tag[i] = '0; m_tgt[i] = '0; m_ins[i] = '0;
        end
    endtask

    task automatic m_update(logic [31:0] pc, bit tk, bit un, logic [31:0] tg, logic [31:0] ins);
        int ix = int'(pc[5:2]);
        if (m_hit(pc)) begin
            if (un) begin m_unc[ix] = 1; m_ctr[ix] = 3; end
            else if (tk) m_ctr[ix] = (m_ctr[ix] == 3) ? 3 : m_ctr[ix] + 1;
            else         m_ctr[ix] = (m_ctr[ix] == 0) ? 0 : m_ctr[ix] - 1;
            if (tk || un) begin m_tgt[ix] = tg; m_ins[ix] = ins; end
        end else if (tk || un) begin
            m_valid[ix] = 1; m_unc[ix] = un; m_ctr[ix] = un ? 3 : 2;
            m_tag[ix] = pc[31:6]; m_tgt[ix] = tg; m_ins[ix] = ins;
        end
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one cycle: drive, compare before the edge, then advance the model at the edge
    task automatic step(string tag, bit lv, logic [31:0] lpc,
                        bit uv, logic [31:0] upc, bit tk, bit un,
                        logic [31:0] tg, logic [31:0] ins);
        bit          eh, et;
        logic [31:0] enx, efi;
        string       rq;
        @(negedge clk);
        lookup_valid = lv; lookup_pc = lpc;
        upd_valid = uv; upd_pc = upc; upd_taken = tk; upd_uncond = un;
        upd_target = tg; upd_target_instr = ins;
        #1;
        eh  = lv && m_hit(lpc);
        et  = lv && m_taken(lpc);
        enx = et ? m_tgt[lpc[5:2]] + 32'd4 : lpc + 32'd4;
        efi = et ? m_ins[lpc[5:2]] : 32'd0;
        rq  = (tag != "") ? tag : (et ? "R4" : (eh ? "R5" : "R3"));
        check(rq, "pred_hit",   32'(pred_hit),   32'(eh));
        check(rq, "pred_taken", 32'(pred_taken), 32'(et));
        check(rq, "fold_valid", 32'(fold_valid), 32'(et));
        check(rq, "next_pc",    next_pc,         enx);
        check(rq, "fold_instr", fold_instr,      efi);
        @(posedge clk);
        if (uv) m_update(upc, tk, un, tg, ins);
    endtask

    task automatic look(string tag, logic [31:0] pc);
        step(tag, 1, pc, 0, 32'h0, 0, 0, 32'h0, 32'h0);
    endtask

    task automatic resolve(logic [31:0] pc, bit tk, bit un, logic [31:0] tg, logic [31:0] ins);
        step("", 0, 32'h0, 1, pc, tk, un, tg, ins);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    localparam logic [31:0] PA = 32'h0000_0100;   // index 0
    localparam logic [31:0] PB = 32'h0000_0140;   // index 0, other tag
    localparam logic [31:0] PC = 32'h0000_0224;   // index 9

    initial begin
        void'($urandom(32'h5eed_0433));
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: empty after reset
        look("R1", PA);
        look("R1", 32'h0000_003c);

        // R7: not-taken miss allocates nothing
        resolve(PA, 0, 0, 32'h1000, 32'hdead_0001);
        look("R7", PA);

        // R10: write and lookup in the same cycle sees the old (empty) entry
        step("R10", 1, PA, 1, PA, 1, 0, 32'h1000, 32'hcafe_0001);
        // R6: the allocation is now visible, weakly taken, folded
        look("R6", PA);

        // R2: alias at the same index and an idle lookup both miss
        look("R2", PB);
        step("R2", 0, PA, 0, 32'h0, 0, 0, 32'h0, 32'h0);

        // R7: not-taken miss at an occupied index leaves the occupant
        resolve(PB, 0, 0, 32'h2000, 32'hbeef_0002);
        look("R7", PA);

        // R8: train down to saturation, keep destination on not-taken
        resolve(PA, 0, 0, 32'h3000, 32'h0bad_0003);
        look("R8", PA);
        resolve(PA, 0, 0, 32'h3000, 32'h0bad_0003);
        resolve(PA, 0, 0, 32'h3000, 32'h0bad_0003);
        look("R8", PA);
        resolve(PA, 1, 0, 32'h4000, 32'h600d_0004);
        look("R8", PA);
        resolve(PA, 1, 0, 32'h4400, 32'h600d_0005);
        look("R8", PA);
        resolve(PA, 1, 0, 32'h4400, 32'h600d_0005);
        resolve(PA, 1, 0, 32'h4400, 32'h600d_0005);
        look("R8", PA);

        // R6: a taken miss replaces the occupant
        resolve(PB, 1, 0, 32'h5000, 32'h1234_0006);
        look("R6", PB);
        look("R6", PA);

        // R9: unconditional entries stay taken through not-taken resolves
        resolve(PC, 0, 1, 32'h6000, 32'h7777_0007);
        look("R9", PC);
        for (int k = 0; k < 4; k++) resolve(PC, 0, 0, 32'h6100, 32'h8888_0008);
        look("R9", PC);

        // R5 with R3 and R4: random mix over a few indexes and tags
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] lp, up;
            lp = ((($urandom % 3) + 1) << 6) | (($urandom % 4) << 2);
            up = ((($urandom % 3) + 1) << 6) | (($urandom % 4) << 2);
            if ($urandom % 8 == 0) lp = $urandom & 32'hffff_fffc;
            step("", ($urandom % 4) != 0, lp,
                 ($urandom % 2) == 0, up, ($urandom % 3) != 0, ($urandom % 10) == 0,
                 $urandom & 32'hffff_fffc, $urandom);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule